// File: doc/BRIEF.md
# Idle Sleep Detector for a Memory Access Port

This block watches the access side of a memory-like device and decides when the device may drop into a low-power sleep state. Every decision is taken on the edges of a fast sampling clock. The block has no chip-enable, write-enable or output-enable inputs, so none of those controls can start or stop sleep. A mode input picks one of two rule sets.

In asynchronous mode, the block counts how long the address bus has stayed the same. Once the address has held for the access time plus a fixed margin, both counted in sampling cycles, the sleep flag goes high. Any later address change clears the flag on the sampling edge that first sees the new address, and the counting starts again.

In synchronous (burst) mode, the address is ignored. Two clock faults on the device clock put the block to sleep. The first is a first high level after a burst start that lasts longer than the access time. The second is a device-clock period longer than a limit set by a parameter. Only a new burst start wakes the block in this mode.

In either mode, a data register follows the read data while the block is awake. While the block sleeps, that register holds the last word it captured, so the output stays readable.

Top module: `idle_sleep_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a sampling edge) clears `sleepFlag` to 0 and `heldData` to 0.
- R2: With `syncMode`=0, `sleepFlag` rises on the sampling edge where the address has been sampled unchanged for ACC_CYCLES+MARGIN_CYCLES (default 29) edges in a row, counted after the edge that first sampled it. It is still 0 one edge earlier.
- R3: With `syncMode`=0, the sampling edge that sees `addrIn` differ from the value sampled at the previous edge clears `sleepFlag`.
- R4: With `syncMode`=1, `sleepFlag` rises when SLOW_CYCLES (default 50) sampling edges pass with no rising edge of `devClk` and no `burstStart`. A device clock with a shorter period never causes sleep.
- R5: With `syncMode`=1, `sleepFlag` rises when the first high level of `devClk` after a `burstStart` is sampled high on ACC_CYCLES+1 (default 15) edges. Later high levels in the same burst do not trigger this rule.
- R6: With `syncMode`=1, an address change does not clear `sleepFlag`. Only `burstStart` sampled high clears it, on that same edge.
- R7: While awake, `heldData` equals `rdData` as sampled at the previous edge. While `sleepFlag` is 1, `heldData` keeps the word it held before sleep was entered.
- R8: Once asleep, the flag stays set for as long as no wake event occurs, no matter how long the idle stretch lasts.
- R9: The mode picks the rules. In asynchronous mode, `devClk` and `burstStart` neither start nor end sleep. In synchronous mode, a stable address does not start sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| syncMode | input | 1 | 0 = asynchronous rules, 1 = synchronous burst rules |
| addrIn | input | ADDR_W | Address bus |
| devClk | input | 1 | Device clock, sampled by `clk` |
| burstStart | input | 1 | High for one sampling cycle when a new burst begins |
| rdData | input | DATA_W | Read data from the array |
| sleepFlag | output | 1 | Block is in the sleep state |
| heldData | output | DATA_W | Registered read data, frozen while asleep |

## Verification
Both outputs are registered, so each result shows up after the sampling edge that takes in the stimulus. A wake event shows on the first edge. An entry caused by a threshold shows after exactly the threshold count of edges following the edge that restarted the count. The bench changes inputs only on falling edges and moves in whole cycles. For each threshold it checks one cycle before the boundary and one cycle on it, so an off-by-one in any counter is caught. Data checks sample `heldData` one edge after `rdData` changes while awake, and several edges after it changes while asleep.

// File: rtl/isd_pkg.sv
package isd_pkg;

  typedef enum logic {
    AWAKE  = 1'b0,
    ASLEEP = 1'b1
  } sleepState_e;

  // control -> datapath
  typedef struct packed {
    logic restart;    // burst start: restart burst timing
    logic countHigh;  // first device-clock level is being measured
    logic loadData;   // capture read data this edge
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic addrChanged;
    logic devFall;
    logic stableHit;
    logic slowHit;
    logic longHit;
  } dpStatus_t;

endpackage

// File: rtl/isd_satcnt.sv
module isd_satcnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hitNext
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;
  logic [W-1:0] cntNext;

  always_comb begin
    if (clr)
      cntNext = '0;
    else if (inc && cnt != LIM)
      cntNext = cnt + 1'b1;
    else
      cntNext = cnt;
  end

  assign hitNext = (cntNext == LIM);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cntNext;
  end
endmodule

// File: rtl/isd_datapath.sv
module isd_datapath
  import isd_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 32,
  parameter int ACC_CYCLES    = 14,
  parameter int MARGIN_CYCLES = 15,
  parameter int SLOW_CYCLES   = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              devClk,
  input  logic [DATA_W-1:0] rdData,
  input  dpStrobe_t         strobe,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] heldData
);
  localparam int STABLE_LIMIT = ACC_CYCLES + MARGIN_CYCLES;
  localparam int LONG_LIMIT   = ACC_CYCLES + 1;

  logic [ADDR_W-1:0] addrQ;
  logic              devClkQ;
  logic              devRise;

  // plain sample registers, loaded during reset as well
  always_ff @(posedge clk) begin
    addrQ   <= addrIn;
    devClkQ <= devClk;
  end

  assign status.addrChanged = (addrIn != addrQ);
  assign devRise            = devClk & ~devClkQ;
  assign status.devFall     = ~devClk & devClkQ;

  isd_satcnt #(.LIMIT(STABLE_LIMIT)) u_stableCnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (status.addrChanged),
    .inc     (1'b1),
    .hitNext (status.stableHit)
  );

  isd_satcnt #(.LIMIT(SLOW_CYCLES)) u_periodCnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (devRise | strobe.restart),
    .inc     (1'b1),
    .hitNext (status.slowHit)
  );

  isd_satcnt #(.LIMIT(LONG_LIMIT)) u_highCnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (strobe.restart),
    .inc     (strobe.countHigh & devClk),
    .hitNext (status.longHit)
  );

  always_ff @(posedge clk) begin
    if (rst)                 heldData <= '0;
    else if (strobe.loadData) heldData <= rdData;
  end
endmodule

// File: rtl/isd_control.sv
module isd_control
  import isd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      syncMode,
  input  logic      burstStart,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      sleepFlag
);
  sleepState_e state, stateNext;
  logic armedQ;
  logic wakeEv;
  logic enterEv;

  always_comb begin
    if (syncMode) begin
      wakeEv  = burstStart;
      enterEv = status.slowHit | status.longHit;
    end else begin
      wakeEv  = status.addrChanged;
      enterEv = status.stableHit;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      AWAKE:  if (!wakeEv && enterEv) stateNext = ASLEEP;
      ASLEEP: if (wakeEv)             stateNext = AWAKE;
      default:                        stateNext = AWAKE;
    endcase
  end

  always_comb begin
    strobe.restart   = burstStart;
    strobe.countHigh = armedQ;
    strobe.loadData  = (stateNext == AWAKE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= AWAKE;
      armedQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (burstStart)          armedQ <= 1'b1;
      else if (status.devFall) armedQ <= 1'b0;
    end
  end

  assign sleepFlag = (state == ASLEEP);
endmodule

// File: rtl/idle_sleep_detector.sv
module idle_sleep_detector
  import isd_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 32,
  parameter int ACC_CYCLES    = 14,
  parameter int MARGIN_CYCLES = 15,
  parameter int SLOW_CYCLES   = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              syncMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              devClk,
  input  logic              burstStart,
  input  logic [DATA_W-1:0] rdData,
  output logic              sleepFlag,
  output logic [DATA_W-1:0] heldData
);
  dpStrobe_t strobe;
  dpStatus_t status;

  isd_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .ACC_CYCLES    (ACC_CYCLES),
    .MARGIN_CYCLES (MARGIN_CYCLES),
    .SLOW_CYCLES   (SLOW_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .addrIn   (addrIn),
    .devClk   (devClk),
    .rdData   (rdData),
    .strobe   (strobe),
    .status   (status),
    .heldData (heldData)
  );

  isd_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .syncMode   (syncMode),
    .burstStart (burstStart),
    .status     (status),
    .strobe     (strobe),
    .sleepFlag  (sleepFlag)
  );
endmodule

// File: rtl/isd_checker.sv
module isd_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              syncMode,
  input logic [ADDR_W-1:0] addrIn,
  input logic              burstStart,
  input logic [DATA_W-1:0] rdData,
  input logic              sleepFlag,
  input logic [DATA_W-1:0] heldData
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!sleepFlag && heldData == '0)); // R1

  AST_ASYNC_ENTRY_STABLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sleepFlag) && !$past(syncMode)) |-> ($past(addrIn) == $past(addrIn, 2))); // R2

  AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (rst)
    (!syncMode && addrIn != $past(addrIn)) |=> !sleepFlag); // R3

  AST_SYNC_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (syncMode && sleepFlag && !burstStart) |=> sleepFlag); // R6

  AST_BURST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (syncMode && burstStart) |=> !sleepFlag); // R6

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    sleepFlag |-> $stable(heldData)); // R7

  AST_DATA_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!sleepFlag && !$past(rst)) |-> (heldData == $past(rdData))); // R7
endmodule

bind idle_sleep_detector isd_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_isdChecker (
  .clk        (clk),
  .rst        (rst),
  .syncMode   (syncMode),
  .addrIn     (addrIn),
  .burstStart (burstStart),
  .rdData     (rdData),
  .sleepFlag  (sleepFlag),
  .heldData   (heldData)
);

// File: tb/tb_idle_sleep_detector.sv
module tb_idle_sleep_detector;
  localparam int ADDR_W   = 20;
  localparam int DATA_W   = 32;
  localparam int ACC      = 14;
  localparam int MARGIN   = 15;
  localparam int SLOW     = 50;
  localparam int STABLE_N = ACC + MARGIN;
  localparam int LONG_N   = ACC + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rd;
    logic [15:0]       ticks;
    logic              expSleep;
  } vec_t;

  // async vectors: new address, data, cycles waited, expected sleep (R2/R3/R8)
  localparam vec_t VECS [6] = '{
    '{20'h00100, 32'h1111_0000, 16'd10,             1'b0},
    '{20'h00101, 32'h2222_0000, 16'(STABLE_N),      1'b0},
    '{20'h00102, 32'h3333_0000, 16'(STABLE_N + 1),  1'b1},
    '{20'h00103, 32'h4444_0000, 16'd1,              1'b0},
    '{20'h00104, 32'h5555_0000, 16'(STABLE_N + 90), 1'b1},
    '{20'h00105, 32'h6666_0000, 16'(STABLE_N - 5),  1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              syncMode = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              devClk = 1'b0;
  logic              burstStart = 1'b0;
  logic [DATA_W-1:0] rdData = '0;
  logic              sleepFlag;
  logic [DATA_W-1:0] heldData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  idle_sleep_detector #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_CYCLES(ACC),
    .MARGIN_CYCLES(MARGIN), .SLOW_CYCLES(SLOW)
  ) dut (
    .clk(clk), .rst(rst), .syncMode(syncMode), .addrIn(addrIn),
    .devClk(devClk), .burstStart(burstStart), .rdData(rdData),
    .sleepFlag(sleepFlag), .heldData(heldData)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseBurst();
    burstStart = 1'b1;
    tick(1);
    burstStart = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rdData = 32'hDEAD_BEEF;
    tick(4);
    check("R1 reset sleep", 32'(sleepFlag), 0);
    check("R1 reset data", heldData, 0);
    rst = 1'b0;

    // table walk, asynchronous mode
    foreach (VECS[i]) begin
      addrIn = VECS[i].addr;
      rdData = VECS[i].rd;
      tick(int'(VECS[i].ticks));
      check($sformatf("R2 vec%0d sleep", i), 32'(sleepFlag), 32'(VECS[i].expSleep));
      check($sformatf("R7 vec%0d data", i), heldData, VECS[i].rd);
    end

    // R7 frozen data while asleep, R9 async ignores burst and devClk
    addrIn = 20'h00200;
    rdData = 32'hAAAA_0001;
    tick(STABLE_N + 1);
    check("R2 enter", 32'(sleepFlag), 1);
    rdData = 32'hBBBB_0002;
    tick(5);
    check("R7 frozen", heldData, 32'hAAAA_0001);
    pulseBurst();
    for (int k = 0; k < 6; k++) begin
      devClk = ~devClk;
      tick(2);
    end
    check("R9 async ignores burst/devClk", 32'(sleepFlag), 1);
    addrIn = 20'h00201;
    tick(1);
    check("R3 wake on address", 32'(sleepFlag), 0);
    check("R7 reload after wake", heldData, 32'hBBBB_0002);

    // synchronous mode: fast clock, stable address -> no sleep (R9, R4)
    syncMode = 1'b1;
    devClk = 1'b0;
    pulseBurst();
    for (int k = 0; k < 30; k++) begin
      devClk = 1'b1; tick(4);
      devClk = 1'b0; tick(4);
    end
    check("R9 sync ignores stable address", 32'(sleepFlag), 0);

    // R4 slow clock boundary
    pulseBurst();
    tick(SLOW - 1);
    check("R4 one before limit", 32'(sleepFlag), 0);
    tick(1);
    check("R4 slow clock enters", 32'(sleepFlag), 1);
    addrIn = 20'h00300;
    rdData = 32'hCCCC_0003;
    tick(3);
    check("R6 address no wake", 32'(sleepFlag), 1);
    tick(200);
    check("R8 stays asleep", 32'(sleepFlag), 1);
    check("R7 frozen sync", heldData, 32'hBBBB_0002);

    // R6 burst wake, then R5 long first level
    pulseBurst();
    check("R6 burst wakes", 32'(sleepFlag), 0);
    check("R7 reload on burst", heldData, 32'hCCCC_0003);
    devClk = 1'b1;
    tick(LONG_N - 1);
    check("R5 one before limit", 32'(sleepFlag), 0);
    tick(1);
    check("R5 long first level enters", 32'(sleepFlag), 1);

    // R5 later long level does not count
    devClk = 1'b0;
    pulseBurst();
    check("R6 burst wakes again", 32'(sleepFlag), 0);
    devClk = 1'b1; tick(3);
    devClk = 1'b0; tick(3);
    devClk = 1'b1; tick(LONG_N + 5);
    check("R5 second level ignored", 32'(sleepFlag), 0);
    devClk = 1'b0; tick(2);

    // R1 reset while asleep
    tick(SLOW);
    check("R4 enter before reset", 32'(sleepFlag), 1);
    rst = 1'b1;
    tick(1);
    check("R1 reset clears sleep", 32'(sleepFlag), 0);
    check("R1 reset clears data", heldData, 0);
    rst = 1'b0;
    tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule